// File: doc/BRIEF.md
# Interrupt Redirection Table

This block routes up to 24 interrupt input lines to interrupt recipients. Each input owns one 64-bit redirection entry that says where its interrupt goes, how it is delivered, which vector it carries, whether the input is edge or level sensitive, and whether it is masked. Software reaches the table through two 32-bit windows. A selector register at offset 0x00 names an internal word, and the data window at offset 0x10 reads or writes that word. Each 64-bit entry is reached as two 32-bit halves.

When an input is seen high, or when software writes any entry, the block scans the pins from the lowest number to the highest. It sends one delivery message for each pin that is pending and unmasked. Messages leave on a valid/ready output, at most one per cycle. The scan waits while the receiver holds ready low. Edge entries latch a rising input and forget it once it is delivered. Level entries mirror the input line, so they are offered again on every scan while the line stays high.

Top module: `irq_redirect_table`

## Requirements
- R1: After reset every entry reads low half 0x00010000 (mask bit 16 set) and high half 0x00000000, the selector reads 0, the ID reads 0, and `msg_valid` is low.
- R2: Offset 0x00 writes and reads back the 8-bit selector in bits 7:0. Offset 0x10 is the data window. Any other offset reads 0, and writes to it change nothing.
- R3: Selector 0 gives the 8-bit ID in bits 31:24 of the window, read and write. The other bits read 0.
- R4: Selector 1 reads 0x00170011 (version 0x11, highest pin number 23 in bits 23:16). Selector 2 reads 0. Writes to selectors 1 and 2 have no effect.
- R5: Selector 0x10+2n is the low half (bits 31:0) of entry n and 0x11+2n is its high half (bits 63:32). A write to one half leaves the other half unchanged.
- R6: Selectors 3 to 0x0F and selectors at or above 0x40 read 0 through the window.
- R7: A message carries destination = entry bits 63:56, logical-destination flag = bit 11, delivery mode = bits 10:8, level flag = bit 15 and vector = bits 7:0.
- R8: Edge entry (bit 15 = 0): a rising input sets the pin pending, and delivering its message clears it. An input held high gives one message only, even across later scans.
- R9: Level entry (bit 15 = 1): the pending state follows the input. Each scan while the input is high delivers one message, and a low input gives none.
- R10: A write to any entry half, or any rising input, starts a scan. Pins are served in ascending order. The first message is valid in the cycle after the clock edge that captured the trigger.
- R11: A masked pin (bit 16 = 1) keeps its pending state and sends nothing. Unmasking it by an entry write delivers its message.
- R12: While `msg_ready` is low the current message stays valid. With ready high, queued messages leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register offset (0x00 selector, 0x10 data window) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_in | input | 24 | Interrupt input lines |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_dest | output | 8 | Destination field |
| msg_dest_logical | output | 1 | Destination mode flag |
| msg_deliv | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-triggered flag |
| msg_vector | output | 8 | Interrupt vector |

## Verification
A register write shows up on a read made after the edge that took it, and a read is combinational, so the bench reads in the same cycle it sets the offset. An input rise or entry write is captured at one edge, and its first message is valid right after that edge. The bench therefore drives on the falling edge and samples one time unit later in the following cycle. Later messages follow one per accepted cycle. The monitor logs a handshake only where valid and ready are both high at that sampling point, which is exactly the cycle the design treats as a transfer.

// File: rtl/irt_pkg.sv
package irt_pkg;

  localparam int ENT_W  = 64;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 8;

  localparam logic [7:0]       VERSION_CODE = 8'h11;
  localparam logic [SEL_W-1:0] SEL_ID       = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER      = 8'h01;
  localparam logic [SEL_W-1:0] SEL_TABLE    = 8'h10;
  localparam logic [ENT_W-1:0] ENT_RESET    = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_logical;
    logic [2:0] deliv;
    logic       level;
    logic [7:0] vector;
  } irt_msg_t;

  typedef struct packed {
    logic             hit;
    logic [SEL_W-1:0] num;
    logic             hi;
  } win_dec_t;

  function automatic irt_msg_t ent_to_msg(input logic [ENT_W-1:0] e);
    irt_msg_t m;
    m.dest         = e[63:56];
    m.dest_logical = e[11];
    m.deliv        = e[10:8];
    m.level        = e[15];
    m.vector       = e[7:0];
    return m;
  endfunction

  function automatic logic ent_masked(input logic [ENT_W-1:0] e);
    return e[16];
  endfunction

  function automatic logic ent_level(input logic [ENT_W-1:0] e);
    return e[15];
  endfunction

  function automatic logic [WORD_W-1:0] version_word(input int pins);
    logic [7:0] top_pin;
    top_pin = 8'(pins - 1);
    return {8'h00, top_pin, 8'h00, VERSION_CODE};
  endfunction

  function automatic win_dec_t decode_sel(input logic [SEL_W-1:0] sel, input int pins);
    win_dec_t d;
    logic [SEL_W-1:0] off;
    off   = sel - SEL_TABLE;
    d.hit = (sel >= SEL_TABLE) && (int'(off >> 1) < pins);
    d.num = off >> 1;
    d.hi  = off[0];
    return d;
  endfunction

endpackage

// File: rtl/irt_regfile.sv
module irt_regfile
  import irt_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              reg_addr,
  input  logic                          reg_wr,
  input  logic [WORD_W-1:0]             reg_wdata,
  output logic [WORD_W-1:0]             reg_rdata,
  output logic [NUM_PINS-1:0][ENT_W-1:0] entries,
  output logic [SEL_W-1:0]              sel_idx,
  output logic                          ent_write
);

  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [SEL_W-1:0] OFF_SEL = 8'h00;
  localparam logic [SEL_W-1:0] OFF_WIN = 8'h10;

  logic [SEL_W-1:0]  sel_q;
  logic [7:0]        id_q;
  win_dec_t          dec;
  logic [PIN_W-1:0]  dec_pin;
  logic              wr_sel;
  logic              wr_win;
  logic [WORD_W-1:0] win_rd;

  assign dec       = decode_sel(sel_q, NUM_PINS);
  assign dec_pin   = dec.num[PIN_W-1:0];
  assign wr_sel    = reg_wr && (reg_addr == OFF_SEL);
  assign wr_win    = reg_wr && (reg_addr == OFF_WIN);
  assign ent_write = wr_win && dec.hit;
  assign sel_idx   = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
      if (wr_win && (sel_q == SEL_ID)) id_q <= reg_wdata[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) entries[p] <= ENT_RESET;
    end else if (ent_write) begin
      if (dec.hi) entries[dec_pin][63:32] <= reg_wdata;
      else        entries[dec_pin][31:0]  <= reg_wdata;
    end
  end

  always_comb begin
    win_rd = '0;
    if (sel_q == SEL_ID)       win_rd = {id_q, 24'h000000};
    else if (sel_q == SEL_VER) win_rd = version_word(NUM_PINS);
    else if (dec.hit)          win_rd = dec.hi ? entries[dec_pin][63:32] : entries[dec_pin][31:0];
    reg_rdata = '0;
    if (reg_addr == OFF_SEL)      reg_rdata = {{(WORD_W-SEL_W){1'b0}}, sel_q};
    else if (reg_addr == OFF_WIN) reg_rdata = win_rd;
  end

endmodule

// File: rtl/irt_pending.sv
module irt_pending #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] level_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] rise,
  output logic                any_rise
);

  logic [NUM_PINS-1:0] irq_q;

  function automatic logic [NUM_PINS-1:0] pend_next(
    input logic [NUM_PINS-1:0] cur, input logic [NUM_PINS-1:0] lvl,
    input logic [NUM_PINS-1:0] line, input logic [NUM_PINS-1:0] up,
    input logic [NUM_PINS-1:0] clr);
    return (lvl & line) | (~lvl & ((cur & ~clr) | up));
  endfunction

  assign rise     = irq_in & ~irq_q;
  assign any_rise = |rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= pend_next(pend, level_vec, irq_in, rise, clr_vec);
    end
  end

endmodule

// File: rtl/irt_scanner.sv
module irt_scanner #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int PTR_W = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                trigger,
  input  logic                msg_ready,
  output logic                active,
  output logic [PTR_W-1:0]    ptr,
  output logic                hit,
  output logic [PIN_W-1:0]    hit_pin,
  output logic                take
);

  logic             again;
  logic [PIN_W:0]   found;

  function automatic logic [PIN_W:0] first_from(
    input logic [NUM_PINS-1:0] v, input logic [PTR_W-1:0] from);
    logic [PIN_W:0] r;
    r = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (v[i] && (i >= int'(from))) r = {1'b1, PIN_W'(i)};
    return r;
  endfunction

  assign found   = first_from(eligible, ptr);
  assign hit     = active && found[PIN_W];
  assign hit_pin = found[PIN_W-1:0];
  assign take    = hit && msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
      again  <= 1'b0;
    end else if (!active) begin
      if (trigger) begin
        active <= 1'b1;
        ptr    <= '0;
      end
    end else if (!hit) begin
      if (again || trigger) begin
        ptr   <= '0;
        again <= 1'b0;
      end else begin
        active <= 1'b0;
      end
    end else begin
      if (take)    ptr   <= PTR_W'(hit_pin) + PTR_W'(1);
      if (trigger) again <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_redirect_table.sv
module irq_redirect_table
  import irt_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_logical,
  output logic [2:0]          msg_deliv,
  output logic                msg_level,
  output logic [7:0]          msg_vector
);

  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int PTR_W = $clog2(NUM_PINS + 1);

  logic [NUM_PINS-1:0][ENT_W-1:0] entries;
  logic [SEL_W-1:0]    sel_idx;
  logic                ent_write;
  logic [NUM_PINS-1:0] mask_vec;
  logic [NUM_PINS-1:0] level_vec;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] rise;
  logic                any_rise;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] eligible;
  logic                trigger;
  logic                active;
  logic [PTR_W-1:0]    ptr;
  logic                hit;
  logic [PIN_W-1:0]    hit_pin;
  logic                take;
  irt_msg_t            msg;

  irt_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .entries(entries),
    .sel_idx(sel_idx), .ent_write(ent_write)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign mask_vec[p]  = ent_masked(entries[p]);
    assign level_vec[p] = ent_level(entries[p]);
  end

  irt_pending #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_vec(level_vec),
    .clr_vec(clr_vec), .pend(pend), .rise(rise), .any_rise(any_rise)
  );

  assign eligible = pend & ~mask_vec;
  assign trigger  = ent_write || any_rise;
  assign clr_vec  = take ? (NUM_PINS'(1) << hit_pin) : '0;

  irt_scanner #(.NUM_PINS(NUM_PINS)) u_scan (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .trigger(trigger),
    .msg_ready(msg_ready), .active(active), .ptr(ptr), .hit(hit),
    .hit_pin(hit_pin), .take(take)
  );

  assign msg              = ent_to_msg(entries[hit_pin]);
  assign msg_valid        = hit;
  assign msg_dest         = msg.dest;
  assign msg_dest_logical = msg.dest_logical;
  assign msg_deliv        = msg.deliv;
  assign msg_level        = msg.level;
  assign msg_vector       = msg.vector;

endmodule

// File: rtl/irt_checker.sv
module irt_checker #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int PTR_W = $clog2(NUM_PINS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          reg_addr,
  input logic [31:0]         reg_rdata,
  input logic [7:0]          sel_idx,
  input logic [NUM_PINS-1:0] irq_in,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] rise,
  input logic [NUM_PINS-1:0] level_vec,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic                active,
  input logic [PTR_W-1:0]    ptr,
  input logic [PIN_W-1:0]    hit_pin,
  input logic                trigger,
  input logic                ent_write,
  input logic                msg_valid,
  input logic                msg_ready
);

  localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_PINS - 1), 8'h00, 8'h11};

  p_version_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h10 && sel_idx == 8'h01) |-> (reg_rdata == VER_EXP));

  p_masked_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !mask_vec[hit_pin]);

  p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && !level_vec[hit_pin] && !rise[hit_pin] && !ent_write)
      |=> !pend[$past(hit_pin)]);

  p_level_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((pend ^ $past(irq_in)) & $past(level_vec)) == '0));

  p_trigger_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> active);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !msg_valid);

  p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ptr <= PTR_W'(NUM_PINS)));

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !ent_write && !level_vec[hit_pin]) |=> msg_valid);

endmodule

bind irq_redirect_table irt_checker #(.NUM_PINS(NUM_PINS)) u_irt_checker (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .sel_idx(sel_idx), .irq_in(irq_in), .pend(pend), .rise(rise),
  .level_vec(level_vec), .mask_vec(mask_vec), .active(active), .ptr(ptr),
  .hit_pin(hit_pin), .trigger(trigger), .ent_write(ent_write),
  .msg_valid(msg_valid), .msg_ready(msg_ready)
);

// File: tb/irq_redirect_table_bench.sv
module irq_redirect_table_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PINS = 24;

  // {pin, high half, low half}; all unmasked
  localparam logic [71:0] VEC_TAB [6] = '{
    {8'd0,  32'h01000000, 32'h00000830},
    {8'd23, 32'hFF000000, 32'h00008531},
    {8'd12, 32'h0F00ABCD, 32'h00002232},
    {8'd5,  32'h80000000, 32'h00000733},
    {8'd17, 32'h42000000, 32'h0000CE34},
    {8'd8,  32'h00000000, 32'h00000135}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [PINS-1:0] irq_in = '0;
  logic            msg_valid;
  logic            msg_ready = 1'b1;
  logic [7:0]      msg_dest;
  logic            msg_dest_logical;
  logic [2:0]      msg_deliv;
  logic            msg_level;
  logic [7:0]      msg_vector;

  int n_chk = 0;
  int n_fail = 0;
  logic [20:0] cap [0:63];
  int cap_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirect_table #(.NUM_PINS(PINS)) u_irq_redirect_table (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_logical(msg_dest_logical), .msg_deliv(msg_deliv),
    .msg_level(msg_level), .msg_vector(msg_vector)
  );

  // handshake monitor: valid and ready both high one unit after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (msg_valid && msg_ready) begin
      if (cap_cnt < 64)
        cap[cap_cnt] = {msg_dest, msg_dest_logical, msg_deliv, msg_level, msg_vector};
      cap_cnt++;
    end
  end

  function automatic logic [20:0] expect_msg(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[31:24], lo[11], lo[10:8], lo[15], lo[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_ent(input int pin, input logic [31:0] lo, input logic [31:0] hi);
    wr(8'h00, 8'(8'h10 + 2*pin));
    wr(8'h10, lo);
    wr(8'h00, 8'(8'h11 + 2*pin));
    wr(8'h10, hi);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 valid", 32'(msg_valid), 32'd0);
    rd(8'h00, d); check("R1 selector", d, 32'h0);
    rd(8'h10, d); check("R1 id", d, 32'h0);
    wr(8'h00, 8'h10); rd(8'h10, d); check("R1 entry0 lo", d, 32'h00010000);
    wr(8'h00, 8'h11); rd(8'h10, d); check("R1 entry0 hi", d, 32'h0);
    wr(8'h00, 8'h3E); rd(8'h10, d); check("R1 entry23 lo", d, 32'h00010000);

    // R2 window offsets
    rd(8'h00, d); check("R2 selector readback", d, 32'h3E);
    rd(8'h08, d); check("R2 other offset", d, 32'h0);
    wr(8'h20, 32'h55); rd(8'h00, d); check("R2 ignored write", d, 32'h3E);

    // R3 identity
    wr(8'h00, 8'h00); wr(8'h10, 32'hA5123456);
    rd(8'h10, d); check("R3 id", d, 32'hA5000000);

    // R4 version and reserved
    wr(8'h00, 8'h01); rd(8'h10, d); check("R4 version", d, 32'h00170011);
    wr(8'h10, 32'hFFFFFFFF); rd(8'h10, d); check("R4 version after write", d, 32'h00170011);
    wr(8'h00, 8'h02); wr(8'h10, 32'h12345678); rd(8'h10, d); check("R4 index2", d, 32'h0);
    wr(8'h00, 8'h00); rd(8'h10, d); check("R4 id untouched", d, 32'hA5000000);

    // R6 outside table
    wr(8'h00, 8'h05); rd(8'h10, d); check("R6 index 0x05", d, 32'h0);
    wr(8'h00, 8'h40); rd(8'h10, d); check("R6 index 0x40", d, 32'h0);
    wr(8'h00, 8'hFF); rd(8'h10, d); check("R6 index 0xFF", d, 32'h0);

    // R5 half writes
    set_ent(3, 32'h00010042, 32'h12000000);
    wr(8'h00, 8'h16); rd(8'h10, d); check("R5 lo", d, 32'h00010042);
    wr(8'h00, 8'h17); rd(8'h10, d); check("R5 hi", d, 32'h12000000);
    wr(8'h00, 8'h16); wr(8'h10, 32'h00010055);
    wr(8'h00, 8'h17); rd(8'h10, d); check("R5 hi kept", d, 32'h12000000);

    // R7 field mapping, table walk
    for (int i = 0; i < 6; i++) begin
      int pin;
      pin = int'(VEC_TAB[i][71:64]);
      set_ent(pin, VEC_TAB[i][31:0], VEC_TAB[i][63:32]);
      base = cap_cnt;
      @(negedge clk); irq_in[pin] = 1'b1;
      @(negedge clk); irq_in[pin] = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      check("R7 count", 32'(cap_cnt - base), 32'd1);
      check("R7 fields", 32'(cap[base]), 32'(expect_msg(VEC_TAB[i][31:0], VEC_TAB[i][63:32])));
      wr(8'h00, 8'(8'h10 + 2*pin));
      wr(8'h10, VEC_TAB[i][31:0] | 32'h00010000);
    end

    // R11 masked pin keeps pending
    set_ent(6, 32'h00010066, 32'h0);
    base = cap_cnt;
    @(negedge clk); irq_in[6] = 1'b1;
    @(negedge clk); irq_in[6] = 1'b0;
    repeat (3) @(negedge clk); #2;
    check("R11 masked silent", 32'(cap_cnt - base), 32'd0);
    wr(8'h00, 8'h1C); wr(8'h10, 32'h00000066);
    repeat (3) @(negedge clk); #2;
    check("R11 unmask count", 32'(cap_cnt - base), 32'd1);
    check("R11 unmask vector", 32'(cap[base][7:0]), 32'h66);

    // R8 edge held high: one message only
    set_ent(4, 32'h00000044, 32'h0);
    base = cap_cnt;
    @(negedge clk); irq_in[4] = 1'b1;
    repeat (3) @(negedge clk); #2;
    check("R8 first", 32'(cap_cnt - base), 32'd1);
    wr(8'h10, 32'h0);
    repeat (3) @(negedge clk); #2;
    check("R8 no repeat", 32'(cap_cnt - base), 32'd1);
    @(negedge clk); irq_in[4] = 1'b0;
    @(negedge clk); irq_in[4] = 1'b1;
    repeat (3) @(negedge clk); #2;
    check("R8 new edge", 32'(cap_cnt - base), 32'd2);
    @(negedge clk); irq_in[4] = 1'b0;

    // R9 level pin
    set_ent(7, 32'h00008077, 32'h0);
    base = cap_cnt;
    @(negedge clk); irq_in[7] = 1'b1;
    repeat (3) @(negedge clk); #2;
    check("R9 first", 32'(cap_cnt - base), 32'd1);
    wr(8'h10, 32'h0);
    repeat (3) @(negedge clk); #2;
    check("R9 rescan while high", 32'(cap_cnt - base), 32'd2);
    @(negedge clk); irq_in[7] = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h10, 32'h0);
    repeat (3) @(negedge clk); #2;
    check("R9 low gives none", 32'(cap_cnt - base), 32'd2);

    // R10 latency and order, R12 stall
    set_ent(2, 32'h00000022, 32'h0);
    set_ent(9, 32'h00000029, 32'h0);
    set_ent(20, 32'h00000040, 32'h0);
    @(negedge clk); msg_ready = 1'b0;
    base = cap_cnt;
    @(negedge clk); irq_in[2] = 1'b1; irq_in[9] = 1'b1; irq_in[20] = 1'b1;
    @(negedge clk); #1;
    check("R10 valid next cycle", 32'(msg_valid), 32'd1);
    check("R10 lowest first", 32'(msg_vector), 32'h22);
    @(negedge clk); #1;
    check("R12 held valid", 32'(msg_valid), 32'd1);
    check("R12 held vector", 32'(msg_vector), 32'h22);
    @(negedge clk); #1;
    check("R12 none taken", 32'(cap_cnt - base), 32'd0);
    @(negedge clk); msg_ready = 1'b1;
    repeat (2) @(negedge clk); #2;
    check("R12 back to back", 32'(cap_cnt - base), 32'd3);
    check("R10 order 1", 32'(cap[base][7:0]), 32'h22);
    check("R10 order 2", 32'(cap[base+1][7:0]), 32'h29);
    check("R10 order 3", 32'(cap[base+2][7:0]), 32'h40);
    @(negedge clk); irq_in = '0;
    repeat (3) @(negedge clk); #1;
    check("R10 idle after scan", 32'(msg_valid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule